// File: doc/BRIEF.md
# Reference-Clocked Oscillator Stop Monitor

This block watches a main oscillator that may fail, for example after a broken resonator connection. It does this from a separate on-chip reference clock that keeps running on its own. The monitored clock is not used as a clock inside the block. It is sampled as data through a synchroniser in the reference domain. A counter measures how long it has been since the last rising edge of the monitored clock. When that time reaches a limit and detection is enabled, the block drives a reset request pulse of fixed width to the chip's reset logic. At the same time it sets a sticky status flag.

The status flag exists so that software, once it runs again after the reset, can tell that the reset came from a lost oscillator. For that reason the chip-level reset input `int_rst_i` clears the enable bit but leaves the flag alone. Only the power-on reset `rst_ni`, or software writing 0 to the flag, clears it. After one request the detector stays quiet until the monitored clock shows a rising edge again. A clock that stays stopped therefore causes exactly one request.

Top module: `osc_stop_mon`

## Requirements
- R1: The control word reads as bit 0 = detection enable, bit 7 = stop status, and bits 6:1 always read 0. After `rst_ni` is asserted the word reads 0x00.
- R2: While the enable bit is 0, `rst_req_o` stays low whatever the monitored clock does.
- R3: With detection enabled, a stop is declared once TIMEOUT reference cycles pass without a rising edge of the monitored clock after its 2-flop synchroniser. When `mon_clk_i` rises just before reference edge 1 and then stays high, `rst_req_o` is first high after reference edge TIMEOUT+4. A clock that rises at least once every TIMEOUT reference cycles never triggers.
- R4: Each reset request is high for exactly PULSE_LEN consecutive reference cycles.
- R5: The status bit becomes 1 on the same reference edge at which a request starts.
- R6: A monitored clock that stays stopped produces only one request. The detector arms again only after a new rising edge of the monitored clock, and the next stop then produces another request.
- R7: A pulse on `int_rst_i` clears the enable bit to 0 and leaves the status bit unchanged.
- R8: A write with bit 7 = 0 clears the status bit. A write with bit 7 = 1 leaves it unchanged. Writes to bits 6:1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running on-chip reference clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low; clears everything |
| int_rst_i | input | 1 | Chip-level reset, synchronous; clears enable only |
| mon_clk_i | input | 1 | Monitored oscillator clock, sampled as data |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Control word read value |
| rst_req_o | output | 1 | Reset request pulse to the reset sequencer |

## Verification
The bench builds the block with TIMEOUT = 8 and PULSE_LEN = 3 instead of 16 and 4. With these values the detection boundary sits at small half-periods of the monitored clock: a half-period of 4 reference cycles just keeps the monitor quiet, and a half-period of 5 just trips it. Both cases fit inside an 80-cycle run per vector. The shorter windows also bring within reach an exact check of the request latency, the pulse width, the single-request behaviour and re-arming, all in a few hundred cycles.

// File: rtl/osc_stop_pkg.sv
package osc_stop_pkg;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned STAT_BIT = 7;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned SYNC_DEF = 2;
endpackage

// File: rtl/osc_sync.sv
module osc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/osc_edge_watch.sv
module osc_edge_watch #(
  parameter int unsigned TIMEOUT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_i,
  input  logic en_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT);

  logic          prev_q;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          stopped;

  assign rise    = mon_i & ~prev_q;
  assign stopped = (cnt_q == LIM);
  assign fire_o  = en_i & armed_q & stopped & ~rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= mon_i;
      if (rise)          cnt_q <= '0;
      else if (!stopped) cnt_q <= cnt_q + 1'b1;
      // one request per stop: disarm until edges return
      if (rise)        armed_q <= 1'b1;
      else if (fire_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_pulse_gen.sv
module osc_pulse_gen #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (trig_i)      cnt_q <= PW'(PULSE_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/osc_stop_mon.sv
module osc_stop_mon
  import osc_stop_pkg::*;
#(
  parameter int unsigned TIMEOUT     = 16,
  parameter int unsigned PULSE_LEN   = 4,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_rst_i,
  input  logic             mon_clk_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             rst_req_o
);
  logic mon_s;
  logic en_q;
  logic stat_q;
  logic fire;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[STAT_BIT-1:EN_BIT+1];

  osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mon_clk_i),
    .q_o   (mon_s)
  );

  osc_edge_watch #(.TIMEOUT(TIMEOUT)) u_watch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mon_i (mon_s),
    .en_i  (en_q),
    .fire_o(fire)
  );

  osc_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (fire),
    .pulse_o(rst_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (int_rst_i)     en_q <= 1'b0;
      else if (reg_wr_i) en_q <= reg_wdata_i[EN_BIT];
      // status survives int_rst_i; only a written 0 clears it, detection wins
      if (fire)                                    stat_q <= 1'b1;
      else if (reg_wr_i && !reg_wdata_i[STAT_BIT]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[EN_BIT]   = en_q;
    reg_rdata_o[STAT_BIT] = stat_q;
  end
endmodule

// File: rtl/osc_stop_mon_chk.sv
module osc_stop_mon_chk #(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_rst_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       rst_req_o
);
  localparam int unsigned HW = $clog2(PULSE_LEN + 2);
  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   hi_cnt_q <= '0;
    else if (!rst_req_o)                           hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(PULSE_LEN + 1))       hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  a_r1_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6:1] == 6'd0);

  a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> $past(reg_rdata_o[0]));

  a_r4_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> hi_cnt_q == HW'(PULSE_LEN));

  a_r5_status_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |-> reg_rdata_o[7]);

  a_r8_status_rise_only_by_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[7]) |-> $rose(rst_req_o));

  a_r7_int_rst_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rst_i && reg_rdata_o[7] && !(reg_wr_i && !reg_wdata_i[7])) |=> reg_rdata_o[7]);

  a_r7_int_rst_clears_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_i |=> !reg_rdata_o[0]);
endmodule

bind osc_stop_mon osc_stop_mon_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .int_rst_i  (int_rst_i),
  .reg_wr_i   (reg_wr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/tb_osc_stop_mon.sv
module tb_osc_stop_mon;
  localparam int unsigned TO = 8;
  localparam int unsigned PL = 3;
  localparam int NV = 6;
  // {half period in ref cycles, expect a request}
  localparam int VEC [NV][2] = '{'{1, 0}, '{2, 0}, '{3, 0}, '{4, 0}, '{5, 1}, '{7, 1}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       int_rst = 1'b0;
  logic       mon = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  osc_stop_mon #(.TIMEOUT(TO), .PULSE_LEN(PL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .int_rst_i(int_rst), .mon_clk_i(mon),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_req_o(req)
  );

  always #5 clk = ~clk;

  task automatic check(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk); rst_n = 1'b0; mon = 1'b0; wr = 1'b0; int_rst = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic run_stuck(input int n, output int pulses, output int hi);
    logic last = req;
    pulses = 0; hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (req) hi++;
      if (req && !last) pulses++;
      last = req;
    end
  endtask

  initial begin
    int p, h, lat;
    por();
    check("R1 reset value", int'(rdata), 0);
    check("R1 reset req low", int'(req), 0);

    // table: monitored clock at various half periods, detection enabled
    for (int v = 0; v < NV; v++) begin
      int seen;
      por();
      write(8'h01);
      seen = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        if (req) seen = 1;
        if ((c % VEC[v][0]) == VEC[v][0] - 1) mon = ~mon;
      end
      check($sformatf("R3 half period %0d", VEC[v][0]), seen, VEC[v][1]);
      check($sformatf("R5 status half period %0d", VEC[v][0]), int'(rdata[7]), VEC[v][1]);
    end

    // R2: disabled, clock stops after one edge
    por();
    @(negedge clk); mon = 1'b1;
    run_stuck(40, p, h);
    check("R2 no req when disabled", p, 0);
    check("R2 status stays 0", int'(rdata[7]), 0);

    // R3 latency, R4 width, R6 single request
    por();
    write(8'h01);
    repeat (3) @(negedge clk);
    mon = 1'b1;
    lat = 0;
    while (!req && lat < 50) begin
      @(negedge clk); lat++;
    end
    check("R3 latency", lat, TO + 4);
    h = 0;
    while (req && h < 20) begin
      @(negedge clk); h++;
    end
    check("R4 pulse width", h, PL);
    run_stuck(40, p, h);
    check("R6 one request per stop", p, 0);

    // R6 rearm: new edge then stop again
    @(negedge clk); mon = 1'b0;
    @(negedge clk); @(negedge clk); mon = 1'b1;
    run_stuck(40, p, h);
    check("R6 rearm pulses", p, 1);
    check("R4 width after rearm", h, PL);

    // R7 internal reset keeps status, clears enable
    @(negedge clk); int_rst = 1'b1;
    @(negedge clk); int_rst = 1'b0;
    check("R7 status kept", int'(rdata[7]), 1);
    check("R7 enable cleared", int'(rdata[0]), 0);

    // R8 write 1 no effect, reserved ignored, write 0 clears
    write(8'hFE);
    check("R8 write 1 keeps status, reserved ignored", int'(rdata), 8'h80);
    write(8'h7F);
    check("R8 write 0 clears, reserved read 0", int'(rdata), 8'h01);
    write(8'h80);
    check("R8 write 1 does not set", int'(rdata[7]), 0);

    // R1 power-on reset clears status
    por();
    write(8'h01);
    @(negedge clk); mon = 1'b1;
    run_stuck(30, p, h);
    check("R5 status after stop", int'(rdata[7]), 1);
    por();
    check("R1 por clears status", int'(rdata), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule